// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address onto a real page address. It uses a small set of programmed block entries and does not walk a page table. Instruction fetches and data accesses each have their own bank of entries, and every entry is a pair of 32-bit words. The upper word holds the effective block index, the block length and two privilege-valid bits. The lower word holds the real block index and a two-bit protection code.

Software programs the entries through a single-word write port, selecting the bank, the entry index and the upper or lower word. A lookup is a one-cycle request carrying the address, the access kind and the privilege level. One clock later the block presents a result with a valid flag, a hit flag, the real page address and a read/write/execute permission vector. When several entries match, the entry with the lowest index wins.

Top module: `blk_xlate_top`

## Requirements
- R1: After reset, vld_o, hit_o, ra_o and perm_o are zero. Every entry word is zero, so no lookup can hit until software programs an entry.
- R2: There are two banks, data (wr_set_i=0, req_fetch_i=0) and instruction (wr_set_i=1, req_fetch_i=1). A write stores wr_data_i into the upper word (wr_hi_i=1) or the lower word (wr_hi_i=0) of entry wr_idx_i in the chosen bank. A lookup reads only the bank named by req_fetch_i, so writes to the other bank do not change its result.
- R3: Upper-word bit 1 enables the entry for supervisor lookups (req_user_i=0). Upper-word bit 0 enables it for user lookups (req_user_i=1). An entry without the bit for the current privilege never hits.
- R4: The effective block index is upper bits 31:17 and the length code is upper bits 12:2. The compare mask is 0xFFFE0000 with the bits of (length code << 15) cleared. An enabled entry hits when (ea & mask) equals (upper & 0xFFFE0000).
- R5: On a hit, ra_o = ((lower & mask) | (ea & ~mask)) with bits 11:0 forced to zero.
- R6: The protection code is lower bits 1:0, and perm_o bit 0 is read, bit 1 is write and bit 2 is execute. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R7: When several entries hit, the result comes from the lowest-indexed one.
- R8: On a miss, hit_o, ra_o and perm_o are all zero.
- R9: vld_o is high exactly in the cycle after req_i was high, and the result reflects the inputs and entries of that request cycle.
- R10: Without a request, hit_o, ra_o and perm_o keep their previous values.
- R11: With NUM_ENT = 0, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_set_i | input | 1 | Bank for write: 0 data, 1 instruction |
| wr_idx_i | input | IDXW | Entry index for write |
| wr_hi_i | input | 1 | 1 upper word, 0 lower word |
| wr_data_i | input | 32 | Write data |
| req_i | input | 1 | Lookup request strobe |
| req_fetch_i | input | 1 | 1 instruction fetch, 0 data access |
| req_user_i | input | 1 | 1 user, 0 supervisor |
| ea_i | input | 32 | Effective address |
| vld_o | output | 1 | Result valid |
| hit_o | output | 1 | Entry matched |
| ra_o | output | 32 | Real page address |
| perm_o | output | 3 | {exec, write, read} |

## Verification
Assertions check the following on every cycle:
- the request-to-valid timing and the holding of results while idle;
- zeroed outputs on a miss;
- page alignment of the real address;
- the legal permission patterns, in which write is never granted without read and execute;
- that a stored word lands in the addressed entry.

Only the bench scenarios can show the other behaviours. These are the arithmetic of the mask over every length code, the privilege gating under each protection code, lowest-index priority when entries overlap, bank separation, and the always-miss configuration.

// File: rtl/blk_xlate_pkg.sv
package blk_xlate_pkg;
  localparam logic [31:0] EPI_FIELD = 32'hFFFE_0000;
  localparam logic [31:0] LEN_FIELD = 32'h0000_1FFC;
  localparam logic [31:0] PAGE_MASK = 32'hFFFF_F000;
  localparam int unsigned LEN_SHIFT = 15;
  localparam int unsigned SV_BIT    = 1;
  localparam int unsigned US_BIT    = 0;

  typedef struct packed {
    logic        hit;
    logic [31:0] ra;
    logic [2:0]  perm;
  } xl_res_t;

  // perm = {exec, write, read}
  function automatic logic [2:0] prot_decode(input logic [1:0] pp);
    case (pp)
      2'd0:    return 3'b000;
      2'd2:    return 3'b111;
      default: return 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/blk_xlate_regs.sv
module blk_xlate_regs #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned IDXW    = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic                        wr_set_i,
  input  logic [IDXW-1:0]             wr_idx_i,
  input  logic                        wr_hi_i,
  input  logic [31:0]                 wr_data_i,
  input  logic                        fetch_i,
  output logic [SLOTS-1:0][31:0]      up_o,
  output logic [SLOTS-1:0][31:0]      lo_o
);
  localparam logic [IDXW:0] ENT_LIM = (IDXW+1)'(NUM_ENT);

  logic [31:0] up_q [2][SLOTS];
  logic [31:0] lo_q [2][SLOTS];

  for (genvar g = 0; g < 2; g++) begin : g_set
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam bit ACTIVE = (s < NUM_ENT);
      logic sel;
      assign sel = ACTIVE && wr_en_i && (wr_set_i == 1'(g)) && (wr_idx_i == IDXW'(s));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          up_q[g][s] <= '0;
          lo_q[g][s] <= '0;
        end else if (sel) begin
          if (wr_hi_i) up_q[g][s] <= wr_data_i;
          else         lo_q[g][s] <= wr_data_i;
        end
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_out
    assign up_o[s] = fetch_i ? up_q[1][s] : up_q[0][s];
    assign lo_o[s] = fetch_i ? lo_q[1][s] : lo_q[0][s];
  end

  // R2
  wr_upper_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i && ({1'b0, wr_idx_i} < ENT_LIM))
    |=> (up_q[$past(wr_set_i)][$past(wr_idx_i)] == $past(wr_data_i)));

  // R2
  wr_lower_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i && ({1'b0, wr_idx_i} < ENT_LIM))
    |=> (lo_q[$past(wr_set_i)][$past(wr_idx_i)] == $past(wr_data_i)));
endmodule

// File: rtl/blk_xlate_entry.sv
module blk_xlate_entry
  import blk_xlate_pkg::*;
(
  input  logic [31:0] up_i,
  input  logic [31:0] lo_i,
  input  logic [31:0] ea_i,
  input  logic        user_i,
  output logic        hit_o,
  output logic [31:0] ra_o,
  output logic [2:0]  perm_o
);
  logic        en;
  logic [31:0] mask;

  assign en     = user_i ? up_i[US_BIT] : up_i[SV_BIT];
  // disabled entry yields an empty mask and cannot hit
  assign mask   = en ? (EPI_FIELD & ~((up_i & LEN_FIELD) << LEN_SHIFT)) : '0;
  assign hit_o  = (mask != '0) && ((ea_i & mask) == (up_i & EPI_FIELD));
  assign ra_o   = ((lo_i & mask) | (ea_i & ~mask)) & PAGE_MASK;
  assign perm_o = prot_decode(lo_i[1:0]);
endmodule

// File: rtl/blk_xlate_prio.sv
module blk_xlate_prio
  import blk_xlate_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic [SLOTS-1:0]            hit_i,
  input  logic [SLOTS-1:0][31:0]      ra_i,
  input  logic [SLOTS-1:0][2:0]       perm_i,
  output xl_res_t                     res_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    res_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hit_i[i] && !found) begin
        found      = 1'b1;
        res_o.hit  = 1'b1;
        res_o.ra   = ra_i[i];
        res_o.perm = perm_i[i];
      end
    end
  end
endmodule

// File: rtl/blk_xlate_top.sv
module blk_xlate_top
  import blk_xlate_pkg::*;
#(
  parameter int unsigned NUM_ENT = 4,
  localparam int unsigned SLOTS  = (NUM_ENT == 0) ? 1 : NUM_ENT,
  localparam int unsigned IDXW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_set_i,
  input  logic [IDXW-1:0] wr_idx_i,
  input  logic            wr_hi_i,
  input  logic [31:0]     wr_data_i,
  input  logic            req_i,
  input  logic            req_fetch_i,
  input  logic            req_user_i,
  input  logic [31:0]     ea_i,
  output logic            vld_o,
  output logic            hit_o,
  output logic [31:0]     ra_o,
  output logic [2:0]      perm_o
);
  logic [SLOTS-1:0][31:0] up_sel, lo_sel;
  logic [SLOTS-1:0]       ent_hit;
  logic [SLOTS-1:0][31:0] ent_ra;
  logic [SLOTS-1:0][2:0]  ent_perm;
  xl_res_t                pick, res_q;
  logic                   vld_q;

  blk_xlate_regs #(.NUM_ENT(NUM_ENT), .SLOTS(SLOTS), .IDXW(IDXW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_set_i (wr_set_i),
    .wr_idx_i (wr_idx_i),
    .wr_hi_i  (wr_hi_i),
    .wr_data_i(wr_data_i),
    .fetch_i  (req_fetch_i),
    .up_o     (up_sel),
    .lo_o     (lo_sel)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_ent
    if (s < NUM_ENT) begin : g_live
      blk_xlate_entry i_entry (
        .up_i  (up_sel[s]),
        .lo_i  (lo_sel[s]),
        .ea_i  (ea_i),
        .user_i(req_user_i),
        .hit_o (ent_hit[s]),
        .ra_o  (ent_ra[s]),
        .perm_o(ent_perm[s])
      );
    end else begin : g_none
      assign ent_hit[s]  = 1'b0;
      assign ent_ra[s]   = '0;
      assign ent_perm[s] = '0;
    end
  end

  blk_xlate_prio #(.SLOTS(SLOTS)) i_prio (
    .hit_i (ent_hit),
    .ra_i  (ent_ra),
    .perm_i(ent_perm),
    .res_o (pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= req_i;
      if (req_i) res_q <= pick;
    end
  end

  assign vld_o  = vld_q;
  assign hit_o  = res_q.hit;
  assign ra_o   = res_q.ra;
  assign perm_o = res_q.perm;

  // R9
  vld_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);

  // R9
  vld_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);

  // R10
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(hit_o) && $stable(ra_o) && $stable(perm_o)));

  // R8
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (ra_o == '0 && perm_o == '0));

  // R5
  page_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ra_o[11:0] == 12'h000);

  // R6
  perm_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (perm_o != 3'b000) |-> (perm_o[0] && perm_o[2]));
endmodule

// File: tb/test_blk_xlate_top.sv
`timescale 1ns/1ps
module test_blk_xlate_top;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_set = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        req = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] ea = '0;
  logic        vld, hit, z_vld, z_hit;
  logic [31:0] ra, z_ra;
  logic [2:0]  perm, z_perm;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] up_m [2][NE];
  logic [31:0] lo_m [2][NE];

  always #4 clk = ~clk;

  blk_xlate_top #(.NUM_ENT(NE)) i_blk_xlate_top (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_set_i(wr_set),
    .wr_idx_i(wr_idx), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .req_i(req), .req_fetch_i(req_fetch), .req_user_i(req_user), .ea_i(ea),
    .vld_o(vld), .hit_o(hit), .ra_o(ra), .perm_o(perm));

  blk_xlate_top #(.NUM_ENT(0)) i_blk_xlate_top_zero (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_set_i(wr_set),
    .wr_idx_i(wr_idx[0]), .wr_hi_i(wr_hi), .wr_data_i(wr_data),
    .req_i(req), .req_fetch_i(req_fetch), .req_user_i(req_user), .ea_i(ea),
    .vld_o(z_vld), .hit_o(z_hit), .ra_o(z_ra), .perm_o(z_perm));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected result from the requirement arithmetic (R3..R8)
  function automatic void model(input bit f, input bit u, input logic [31:0] a,
                                output logic h, output logic [31:0] r, output logic [2:0] p);
    h = 0; r = '0; p = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      logic [31:0] up, lo, m;
      logic [10:0] len;
      up  = up_m[f][i];
      lo  = lo_m[f][i];
      len = up[12:2];
      m   = 32'hFFFE_0000 & ~({4'b0, len, 17'b0});
      if ((u ? up[0] : up[1]) && ((a & m) == (up & 32'hFFFE_0000))) begin
        h = 1;
        r = {((lo & m) | (a & ~m))} & 32'hFFFF_F000;
        p = (lo[1:0] == 2'd0) ? 3'b000 : (lo[1:0] == 2'd2) ? 3'b111 : 3'b101;
      end
    end
  endfunction

  task automatic wr(input bit s, input int i, input bit hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_set = s; wr_idx = 2'(i); wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (hi) up_m[s][i] = d; else lo_m[s][i] = d;
  endtask

  task automatic look(input bit f, input bit u, input logic [31:0] a, input string tag);
    logic eh; logic [31:0] er; logic [2:0] ep;
    @(negedge clk);
    req = 1; req_fetch = f; req_user = u; ea = a;
    @(negedge clk);
    req = 0;
    model(f, u, a, eh, er, ep);
    chk({tag, " R9 vld"}, 32'(vld), 32'd1);
    chk({tag, " hit"}, 32'(hit), 32'(eh));
    chk({tag, " ra"}, ra, er);
    chk({tag, " perm"}, 32'(perm), 32'(ep));
    chk("R11 zero-entry hit", 32'(z_hit), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic h_s; logic [31:0] r_s; logic [2:0] p_s;
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < NE; i++) begin up_m[s][i] = '0; lo_m[s][i] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vld", 32'(vld), 0);
    chk("R1 hit", 32'(hit), 0);
    chk("R1 ra", ra, 0);
    chk("R1 perm", 32'(perm), 0);
    rst_n = 1;
    look(0, 0, 32'h0000_0000, "R1 R8 empty");
    look(1, 1, 32'h1234_5678, "R1 R8 empty");

    // R3 R6: privilege bits x protection codes
    for (int vb = 0; vb < 4; vb++)
      for (int pp = 0; pp < 4; pp++) begin
        wr(0, 0, 1, 32'h2000_0000 | 32'(vb));
        wr(0, 0, 0, 32'h8000_0000 | 32'(pp));
        for (int u = 0; u < 2; u++) look(0, u[0], 32'h2001_5ABC, "R3 R6 sweep");
      end

    // R4 R5: every length code
    wr(0, 0, 1, 32'h0);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] base, size;
      base = 32'h4000_0000;
      size = 32'h0002_0000 << k;
      wr(0, 1, 1, base | (32'((1 << k) - 1) << 2) | 32'h3);
      wr(0, 1, 0, 32'hA000_0000 | 32'h2);
      look(0, 0, base + size - 32'd1, "R4 R5 len top");
      look(0, 1, base + (size >> 1) + 32'h0000_1234, "R4 R5 len mid");
      look(0, 0, base + size, "R4 past end");
      look(0, 0, base - 32'd1, "R4 before start");
    end
    // R4: index bit inside the length region blocks any hit
    wr(0, 1, 1, 32'h4002_0000 | (32'h1 << 2) | 32'h3);
    look(0, 0, 32'h4002_0000, "R4 misaligned index");
    look(0, 0, 32'h4000_0000, "R4 misaligned index");

    // R7 priority
    for (int i = 0; i < NE; i++) begin
      wr(0, i, 1, 32'h6000_0003);
      wr(0, i, 0, (32'(i + 1) << 28) | 32'(i % 3));
    end
    look(0, 0, 32'h6000_4000, "R7 all hit");
    wr(0, 0, 1, 32'h6000_0000);
    look(0, 0, 32'h6000_4000, "R7 first off");
    wr(0, 1, 1, 32'h6000_0001);
    look(0, 0, 32'h6000_4000, "R7 R3 user-only skipped");
    look(0, 1, 32'h6000_4000, "R7 R3 user-only taken");

    // R2 bank separation
    wr(1, 0, 1, 32'h6000_0003);
    wr(1, 0, 0, 32'hC000_0001);
    look(1, 0, 32'h6001_F000, "R2 fetch bank");
    look(0, 0, 32'h6001_F000, "R2 data bank");
    wr(0, 2, 0, 32'hE000_0002);
    look(1, 0, 32'h6001_F000, "R2 fetch unaffected");
    look(0, 1, 32'h7000_0000, "R2 R8 miss");

    // R10 hold while idle, R9 vld drops
    look(1, 1, 32'h6000_0000, "R10 setup");
    h_s = hit; r_s = ra; p_s = perm;
    repeat (3) @(negedge clk);
    chk("R9 vld idle", 32'(vld), 0);
    chk("R10 hit held", 32'(hit), 32'(h_s));
    chk("R10 ra held", ra, r_s);
    chk("R10 perm held", 32'(perm), 32'(p_s));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule